// File: doc/BRIEF.md
# Microcoded 8-bit Accumulator Processor

This block is a small multi-cycle processor built around one accumulator. Sixteen bytes of RAM hold both the program and its data. Each instruction byte carries a 4-bit operation code in bits 7..4 and a 4-bit operand in bits 3..0. The operand is either a memory address or an immediate value.

A microcode sequencer steps through five microsteps per instruction and emits a 17-bit control word. That word drives an internal 8-bit bus connecting these parts:

- the program counter
- the memory address register
- the RAM
- the instruction register
- the A and B registers
- an adder/subtractor with latched carry and zero flags
- an output register

Before a run, the RAM image is written through a preload port. While that port is active the sequencer is paused. The integrator then releases the synchronous reset and watches the output register, its one-cycle valid strobe and the halted flag.

Top module: `acc_cpu`

## Requirements
- R1: Every instruction occupies exactly five clock cycles, so instruction n (counting from 0 after reset release) performs its execute microstep on rising edge 5n+3. The program counter advances by one during fetch and wraps from 15 to 0.
- R2: Opcode 1 loads A from the addressed byte. Opcode 5 loads the 4-bit operand into A bits 3..0 and clears A bits 7..4.
- R3: Opcode 2 loads the addressed byte into B and writes (A+B) mod 256 into A. Carry is set when A+B exceeds 255, and zero is set when the result is 0.
- R4: Opcode 3 loads the addressed byte into B and writes (A−B) mod 256 into A. Carry is set when A ≥ B (no borrow), and zero is set when the result is 0.
- R5: The carry and zero flags change only on opcodes 2 and 3. Every other opcode leaves them as they were.
- R6: Opcode 4 writes A to the addressed byte. RAM contents survive reset.
- R7: Opcode 6 always loads the program counter with the operand. Opcode 7 does so only when carry is set, and opcode 8 only when zero is set. The carry-conditioned jump is enabled by bit 0 of the 17-bit control word.
- R8: Opcode E copies A to the output port on the execute edge. The output strobe is high for exactly the one cycle that follows.
- R9: Opcode F sets the halted flag on its execute edge. After that, nothing changes until reset: no strobe, output held, flag held.
- R10: Opcode 0 and opcodes 9 to D do nothing, whatever their operand is.
- R11: Reset clears the program counter, all registers, the flags, the step counter and the halted flag. While the preload enable is high, each cycle writes the preload data to the preload address, and the sequencer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write enable; pauses the sequencer |
| ld_addr | input | 4 | Preload RAM address |
| ld_data | input | 8 | Preload RAM data |
| out_val | output | 8 | Output register |
| out_stb | output | 1 | One-cycle pulse after the output register loads |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Edges are counted from the first rising edge after reset is released. The execute microstep of instruction n lands on edge 5n+3. The output value and its strobe therefore appear just after that edge, and the halted flag rises on the same edge for a halt instruction.

The bench runs an instruction-level model of each program to predict every output value and its edge number. It samples one time unit after each rising edge and compares both value and edge. Once the machine halts, the bench watches eight further cycles for silence.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP = 4'h0,
        OPC_LDM = 4'h1,
        OPC_ADD = 4'h2,
        OPC_SUB = 4'h3,
        OPC_STM = 4'h4,
        OPC_LDK = 4'h5,
        OPC_JMP = 4'h6,
        OPC_JCY = 4'h7,
        OPC_JZR = 4'h8,
        OPC_SHO = 4'hE,
        OPC_STP = 4'hF
    } opcode_e;

    // 17-bit control word; the last field lands on bit 0 (carry-conditioned jump)
    typedef struct packed {
        logic halt;
        logic pc_out;
        logic pc_inc;
        logic mar_in;
        logic ram_out;
        logic ram_in;
        logic ir_in;
        logic opd_out;
        logic a_in;
        logic a_out;
        logic alu_out;
        logic alu_sub;
        logic b_in;
        logic out_in;
        logic jmp;
        logic jz;
        logic jc;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         zero
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
        res  = wide[W-1:0];
        cout = wide[W];
        zero = (wide[W-1:0] == '0);
    end
endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (pre_we) begin
            mem_q[pre_addr] <= pre_data;
        end else if (cpu_we) begin
            mem_q[cpu_addr] <= cpu_data;
        end
    end

    assign rd_data = mem_q[cpu_addr];
endmodule

// File: rtl/acc_cpu_ucode.sv
module acc_cpu_ucode
    import acc_cpu_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic [OP_W-1:0]   op,
    input  logic [STEP_W-1:0] step,
    output ctrl_t             cw
);
    localparam logic [STEP_W-1:0] T_ADR = STEP_W'(0);
    localparam logic [STEP_W-1:0] T_INS = STEP_W'(1);
    localparam logic [STEP_W-1:0] T_EX0 = STEP_W'(2);
    localparam logic [STEP_W-1:0] T_EX1 = STEP_W'(3);
    localparam logic [STEP_W-1:0] T_EX2 = STEP_W'(4);

    always_comb begin
        cw = '0;
        if (step == T_ADR) begin
            cw.pc_out = 1'b1;
            cw.mar_in = 1'b1;
        end else if (step == T_INS) begin
            cw.ram_out = 1'b1;
            cw.ir_in   = 1'b1;
            cw.pc_inc  = 1'b1;
        end else begin
            case (opcode_e'(op))
                OPC_LDM: begin
                    if (step == T_EX0) begin
                        cw.opd_out = 1'b1;
                        cw.mar_in  = 1'b1;
                    end
                    if (step == T_EX1) begin
                        cw.ram_out = 1'b1;
                        cw.a_in    = 1'b1;
                    end
                end
                OPC_ADD, OPC_SUB: begin
                    if (step == T_EX0) begin
                        cw.opd_out = 1'b1;
                        cw.mar_in  = 1'b1;
                    end
                    if (step == T_EX1) begin
                        cw.ram_out = 1'b1;
                        cw.b_in    = 1'b1;
                    end
                    if (step == T_EX2) begin
                        cw.alu_out = 1'b1;
                        cw.a_in    = 1'b1;
                        cw.alu_sub = (opcode_e'(op) == OPC_SUB);
                    end
                end
                OPC_STM: begin
                    if (step == T_EX0) begin
                        cw.opd_out = 1'b1;
                        cw.mar_in  = 1'b1;
                    end
                    if (step == T_EX1) begin
                        cw.a_out  = 1'b1;
                        cw.ram_in = 1'b1;
                    end
                end
                OPC_LDK: begin
                    if (step == T_EX0) begin
                        cw.opd_out = 1'b1;
                        cw.a_in    = 1'b1;
                    end
                end
                OPC_JMP: begin
                    if (step == T_EX0) begin
                        cw.opd_out = 1'b1;
                        cw.jmp     = 1'b1;
                    end
                end
                OPC_JCY: begin
                    if (step == T_EX0) begin
                        cw.opd_out = 1'b1;
                        cw.jc      = 1'b1;
                    end
                end
                OPC_JZR: begin
                    if (step == T_EX0) begin
                        cw.opd_out = 1'b1;
                        cw.jz      = 1'b1;
                    end
                end
                OPC_SHO: begin
                    if (step == T_EX0) begin
                        cw.a_out  = 1'b1;
                        cw.out_in = 1'b1;
                    end
                end
                OPC_STP: begin
                    if (step == T_EX0) cw.halt = 1'b1;
                end
                default: cw = '0;
            endcase
        end
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int STEPS  = 5,
    localparam int DATA_W = OP_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] out_val,
    output logic              out_stb,
    output logic              halted
);
    localparam int STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] outr;
        logic              ostb;
        logic              carry;
        logic              zero;
        logic              halted;
        logic [STEP_W-1:0] step;
    } state_t;

    state_t            s_q, s_d;
    ctrl_t             cw;
    logic              run;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout, alu_zero;
    logic              take_jump;

    assign run = !s_q.halted && !ld_en;

    acc_cpu_ucode #(.STEP_W(STEP_W)) u_ucode (
        .op   (s_q.ir[DATA_W-1 -: OP_W]),
        .step (s_q.step),
        .cw   (cw)
    );

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .a    (s_q.a),
        .b    (s_q.b),
        .sub  (cw.alu_sub),
        .res  (alu_res),
        .cout (alu_cout),
        .zero (alu_zero)
    );

    acc_cpu_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk      (clk),
        .pre_we   (ld_en),
        .pre_addr (ld_addr),
        .pre_data (ld_data),
        .cpu_we   (cw.ram_in && run),
        .cpu_addr (s_q.mar),
        .cpu_data (bus),
        .rd_data  (ram_rd)
    );

    // single-driver bus: microcode asserts at most one source per step
    always_comb begin
        if (cw.pc_out)       bus = DATA_W'(s_q.pc);
        else if (cw.ram_out) bus = ram_rd;
        else if (cw.opd_out) bus = DATA_W'(s_q.ir[ADDR_W-1:0]);
        else if (cw.a_out)   bus = s_q.a;
        else if (cw.alu_out) bus = alu_res;
        else                 bus = '0;
    end

    assign take_jump = cw.jmp || (cw.jc && s_q.carry) || (cw.jz && s_q.zero);

    always_comb begin
        s_d      = s_q;
        s_d.ostb = 1'b0;
        if (run) begin
            s_d.step = (s_q.step == LAST_STEP) ? '0 : s_q.step + 1'b1;
            if (cw.mar_in) s_d.mar = bus[ADDR_W-1:0];
            if (cw.ir_in)  s_d.ir  = bus;
            if (cw.a_in)   s_d.a   = bus;
            if (cw.b_in)   s_d.b   = bus;
            if (cw.pc_inc) s_d.pc  = s_q.pc + 1'b1;
            if (take_jump) s_d.pc  = bus[ADDR_W-1:0];
            if (cw.alu_out) begin
                s_d.carry = alu_cout;
                s_d.zero  = alu_zero;
            end
            if (cw.out_in) begin
                s_d.outr = bus;
                s_d.ostb = 1'b1;
            end
            if (cw.halt) s_d.halted = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_val = s_q.outr;
    assign out_stb = s_q.ostb;
    assign halted  = s_q.halted;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int ADDR_W = 4,
    parameter int STEPS  = 5,
    parameter int DATA_W = 8,
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              flag_wr,
    input logic [STEP_W-1:0] step,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input logic              carry,
    input logic              zero,
    input logic [DATA_W-1:0] out_val,
    input logic              out_stb,
    input logic              halted
);
    p_step_bound_r1: assert property (@(posedge clk) disable iff (rst)
        int'(step) < STEPS);

    p_pc_fetch_inc_r1: assert property (@(posedge clk) disable iff (rst)
        (run && step == STEP_W'(1)) |=> pc == ADDR_W'($past(pc) + 1'b1));

    p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(run && flag_wr) |=> ($stable(carry) && $stable(zero)));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        out_stb |=> !out_stb);

    p_out_from_acc_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_stb) |-> out_val == $past(acc));

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(out_val) && !out_stb && $stable(pc) && $stable(acc)));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (out_val == '0 && !out_stb && !halted && pc == '0 && step == '0));
endmodule

bind acc_cpu acc_cpu_chk #(
    .ADDR_W (ADDR_W),
    .STEPS  (STEPS),
    .DATA_W (DATA_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .flag_wr (cw.alu_out),
    .step    (s_q.step),
    .pc      (s_q.pc),
    .acc     (s_q.a),
    .carry   (s_q.carry),
    .zero    (s_q.zero),
    .out_val (out_val),
    .out_stb (out_stb),
    .halted  (halted)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] out_val;
    logic       out_stb;
    logic       halted;

    always #5 clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .out_val (out_val),
        .out_stb (out_stb),
        .halted  (halted)
    );

    int checks = 0;
    int errors = 0;
    int gcyc   = 0;

    logic [7:0] img [16];
    int exp_v [1024];
    int exp_c [1024];
    int n_exp;
    int exp_halt;

    always @(posedge clk) begin
        gcyc++;
        if (gcyc == 190000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", gcyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // instruction-level model: fills expected outputs with their edge numbers
    task automatic model(int max_outs);
        int pc = 0, a = 0, c = 0, z = 0;
        n_exp = 0;
        exp_halt = -1;
        for (int n = 0; n < 4000; n++) begin
            int op, x, m;
            op = int'(img[pc][7:4]);
            x  = int'(img[pc][3:0]);
            m  = int'(img[x]);
            pc = (pc + 1) % 16;
            case (op)
                1: a = m;
                2: begin c = (a + m > 255); a = (a + m) % 256; z = (a == 0); end
                3: begin c = (a >= m); a = (a - m + 256) % 256; z = (a == 0); end
                4: img[x] = 8'(a);
                5: a = x;
                6: pc = x;
                7: if (c != 0) pc = x;
                8: if (z != 0) pc = x;
                14: begin
                    exp_v[n_exp] = a;
                    exp_c[n_exp] = 5 * n + 3;
                    n_exp++;
                    if (n_exp == max_outs) return;
                end
                15: begin exp_halt = 5 * n + 3; return; end
                default: ;
            endcase
        end
    endtask

    task automatic load();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            ld_en   = 1'b1;
            ld_addr = 4'(i);
            ld_data = img[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
    endtask

    task automatic run(string tag, int max_outs);
        int cyc = 0, idx = 0, limit;
        logic [7:0] held;
        model(max_outs);
        limit = (exp_halt >= 0) ? exp_halt + 10 : exp_c[n_exp-1] + 10;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "reset out_val", int'(out_val), 0);
        chk("R11", "reset strobe", int'(out_stb), 0);
        chk("R11", "reset halted", int'(halted), 0);
        rst = 1'b0;
        while (cyc < limit) begin
            @(posedge clk);
            #1;
            cyc++;
            if (out_stb) begin
                if (idx < n_exp) begin
                    chk(tag, "output value", int'(out_val), exp_v[idx]);
                    chk({tag, "/R1/R8"}, "output edge", cyc, exp_c[idx]);
                end else begin
                    chk({tag, "/R8"}, "extra output", 1, 0);
                end
                idx++;
            end
            if (halted) break;
            if (exp_halt < 0 && idx == n_exp) break;
        end
        chk(tag, "output count", idx, n_exp);
        if (exp_halt >= 0) begin
            chk("R9", "halt edge", halted ? cyc : -1, exp_halt);
            held = out_val;
            repeat (8) begin
                @(posedge clk);
                #1;
                chk("R9", "quiet strobe", int'(out_stb), 0);
                chk("R9", "held output", int'(out_val), int'(held));
                chk("R9", "still halted", int'(halted), 1);
            end
        end
    endtask

    initial begin
        logic [7:0] sweep [16];
        sweep = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h0F, 8'h10, 8'h33, 8'h40,
                  8'h55, 8'h7F, 8'h80, 8'h81, 8'hAA, 8'hC0, 8'hFE, 8'hFF};

        repeat (3) @(negedge clk);
        chk("R11", "initial out_val", int'(out_val), 0);
        chk("R11", "initial halted", int'(halted), 0);

        // R3: count up by one, wrap 255 -> 0 sets carry and halts
        img = '{8'hE0, 8'h2F, 8'h74, 8'h60, 8'hF0, 8'h00, 8'h00, 8'h00,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01};
        load();
        run("R3", 1024);

        // R4: count down from 255 to 0, stop on zero
        img = '{8'h1E, 8'hE0, 8'h85, 8'h3F, 8'h61, 8'hF0, 8'h00, 8'h00,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h01};
        load();
        run("R4", 1024);

        // R5 and R2: flags survive load-immediate; immediate clears upper nibble
        img = '{8'h1F, 8'h2F, 8'h57, 8'h85, 8'hF0, 8'hE0, 8'h1E, 8'h52,
                8'hE0, 8'h7B, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'hF3, 8'h00};
        load();
        run("R5/R2", 1024);

        // R7: unconditional jumps
        img = '{8'h59, 8'h64, 8'hE0, 8'hF0, 8'hE0, 8'h62, 8'h00, 8'h00,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        load();
        run("R7", 1024);

        // R6: store then rerun after reset without reload
        img = '{8'h1F, 8'h2E, 8'h4F, 8'h50, 8'h1F, 8'hE0, 8'hF0, 8'h00,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h10};
        load();
        run("R6", 1024);
        run("R6/R11", 1024);

        // R1 and R10: no-op codes 0 and 9..D, program counter wraps 15 -> 0
        img = '{8'h2F, 8'hE0, 8'h9A, 8'hA5, 8'hB0, 8'hC3, 8'hDF, 8'h0F,
                8'h03, 8'h9F, 8'hA0, 8'hBB, 8'hCC, 8'hD4, 8'h00, 8'h01};
        load();
        run("R10", 5);

        // R3/R4/R7 sweep: result, carry-branch and zero-branch outputs
        for (int op = 2; op <= 3; op++) begin
            for (int ia = 0; ia < 16; ia++) begin
                for (int ib = 0; ib < 16; ib++) begin
                    img = '{8'h1E, 8'h2F, 8'hE0, 8'h76, 8'h50, 8'h67, 8'h51, 8'hE0,
                            8'h8B, 8'h50, 8'h6C, 8'h51, 8'hE0, 8'hF0, 8'h00, 8'h00};
                    img[1]  = {4'(op), 4'hF};
                    img[14] = sweep[ia];
                    img[15] = sweep[ib];
                    load();
                    run((op == 2) ? "R3/R7" : "R4/R7", 1024);
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule